// File: doc/BRIEF.md
# Boost Frequency Target Calculator

This block sits behind a hardware activity monitor and turns its events into a frequency request for a memory clock. Each event is one of three kinds. A sustained-high report makes a per-channel boost value grow by a percentage and then by a fixed step. A sustained-low report makes the boost shrink by a percentage. A plain sample leaves the boost as it is. For every event the block also computes these values, all from the same inputs:
- a band around the latest average count, giving the average watermarks;
- the raw upper and lower watermarks, scaled from the current frequency;
- a target frequency, which is the average rescaled plus the boost.

It also returns two re-arm flags for the sustained-high and sustained-low interrupts. Whenever the boost saturates at the maximum frequency, or collapses to zero, the flag for that direction is switched off.

An event enters on a valid/ready handshake. It is accepted only while the block is idle, so `ev_ready` is low from acceptance until the result has been handed off. The results come back on a second valid/ready pair. `res_valid` stays high and every result output stays frozen until `res_ready` is seen high on a clock edge. All divisions by 100, 12 and 1000 share one iterative restoring divider. One event therefore takes a few hundred cycles.

Top module: `boost_tgt_calc`

## Requirements
- R1: `ev_ready` is high only when the block is idle. An accepted event drops `ev_ready` on the next edge. `ev_ready` and `res_valid` are never high together. While `res_valid` is high and `res_ready` is low, all result outputs hold their values. One edge with `res_ready` high returns the block to idle.
- R2: Event kind 2'b01 (sustained high) computes a candidate boost of boost×grow/100 + 16000. If the candidate is greater than or equal to `max_freq`, the new boost is `max_freq`; otherwise it is the candidate.
- R3: After kind 2'b01, `arm_below` is 1. `arm_above` is 1 only when the boost was not clamped to `max_freq`.
- R4: Event kind 2'b10 (sustained low) gives boost×decay/100. A result under 8000 becomes 0 and clears `arm_below`; otherwise `arm_below` is 1.
- R5: After kind 2'b10, `arm_above` is 1.
- R6: Kinds 2'b00 and 2'b11 leave the boost unchanged. They copy `arm_in[1]` to `arm_above` and `arm_in[0]` to `arm_below`, subject only to R7.
- R7: Channel 1 has a dependency floor of 50000 and channel 0 has none. On channel 1, an average of at least 50000 forces `arm_below` to 1. An average under 50000 with a resulting boost of 0 forces `arm_below` to 0.
- R8: The band is computed as (max_freq×6/1000)×12. `avg_wm_hi` = avg + band, and `avg_wm_lo` = max(avg, band) − band.
- R9: `raw_wm_hi` = cur×12×hi/100 and `raw_wm_lo` = cur×12×lo/100. Channel 0 uses hi/lo of 60/40 with grow/decay of 200/50. Channel 1 uses 27/10 with 800/90.
- R10: `target_out` = (avg/12)×S/100 + boost, where S is 10000/hi: 166 on channel 0 and 370 on channel 1.
- R11: On channel 1 with avg ≥ 50000, `target_out` is raised to at least a rate looked up from `cpu_freq`, capped at `max_freq`. The lookup uses the first match, in this order:

  | `cpu_freq` at least | Rate |
  |---|---|
  | 1400000 | max |
  | 1200000 | 750000 |
  | 1100000 | 600000 |
  | 1000000 | 500000 |
  | 800000 | 375000 |
  | 500000 | 200000 |
  | 250000 | 100000 |
  | below 250000 | 0 |

- R12: Each channel keeps its own boost. Every boost is 0 after reset, and an event on one channel leaves the other channel's boost untouched.
- R13: All results saturate at 2^32−1 instead of wrapping. This covers the boost, the watermarks and the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Block idle, event taken on this edge |
| ev_kind | input | 2 | 00 sample, 01 sustained high, 10 sustained low, 11 sample |
| ev_chan | input | 1 | Coefficient set and boost register select |
| avg_cnt | input | 32 | Latest average activity count |
| cur_freq | input | 32 | Current memory clock rate |
| max_freq | input | 32 | Highest allowed rate |
| cpu_freq | input | 32 | Processor rate for the floor lookup |
| arm_in | input | 2 | Present re-arm flags, [1] above, [0] below |
| res_valid | output | 1 | Results valid |
| res_ready | input | 1 | Results consumed |
| boost_out | output | 32 | New boost of the selected channel |
| target_out | output | 32 | Target frequency |
| avg_wm_hi | output | 32 | Average upper watermark |
| avg_wm_lo | output | 32 | Average lower watermark |
| raw_wm_hi | output | 32 | Raw upper watermark |
| raw_wm_lo | output | 32 | Raw lower watermark |
| arm_below | output | 1 | Re-arm sustained-low interrupt |
| arm_above | output | 1 | Re-arm sustained-high interrupt |

## Verification
The hardest case to reach from the ports is a boost that saturates the 32-bit range before it reaches the clamp. Getting there needs a long chain of sustained-high events on the fast-growing channel, with `max_freq` at its top value. The bench drives seven such events in a row and computes the expected growth itself. The chain ends in a wide candidate that must saturate, then clamp, and then clear `arm_above`.

The forced-off case of the dependency rule is also hard to reach. It needs a boost of exactly zero on channel 1, and a freshly reset block reaches that directly. The bench therefore resets again before that test.

// File: rtl/btc_pkg.sv
package btc_pkg;
  localparam int CW       = 16;
  localparam int NSET     = 2;
  localparam int STEP     = 16000;
  localparam int FLOOR    = STEP / 2;
  localparam int PERIOD   = 12;
  localparam int BAND_PPT = 6;
  localparam int PCT      = 100;
  localparam int PPT      = 1000;
  localparam int LUT_ROWS = 7;

  typedef enum logic [1:0] {
    EV_SAMPLE     = 2'b00,
    EV_UPPER      = 2'b01,
    EV_LOWER      = 2'b10,
    EV_SAMPLE_ALT = 2'b11
  } ev_kind_e;

  typedef struct packed {
    logic [CW-1:0] grow_pct;
    logic [CW-1:0] decay_pct;
    logic [CW-1:0] hi_pct;
    logic [CW-1:0] lo_pct;
    logic [CW-1:0] sustain;
    logic [31:0]   dep_floor;
  } coef_t;

  function automatic coef_t coef_of(input int unsigned idx);
    coef_t c;
    case (idx)
      1: c = '{grow_pct: 16'd800, decay_pct: 16'd90, hi_pct: 16'd27, lo_pct: 16'd10,
               sustain: 16'(10000 / 27), dep_floor: 32'd50000};
      default: c = '{grow_pct: 16'd200, decay_pct: 16'd50, hi_pct: 16'd60, lo_pct: 16'd40,
                     sustain: 16'(10000 / 60), dep_floor: 32'd0};
    endcase
    return c;
  endfunction

  // Rows are searched from index 0; the first key not above the input wins.
  function automatic logic [31:0] lut_key(input int idx);
    case (idx)
      0: return 32'd1400000;
      1: return 32'd1200000;
      2: return 32'd1100000;
      3: return 32'd1000000;
      4: return 32'd800000;
      5: return 32'd500000;
      default: return 32'd250000;
    endcase
  endfunction

  function automatic logic [31:0] lut_val(input int idx);
    case (idx)
      0: return 32'hFFFF_FFFF;
      1: return 32'd750000;
      2: return 32'd600000;
      3: return 32'd500000;
      4: return 32'd375000;
      5: return 32'd200000;
      default: return 32'd100000;
    endcase
  endfunction
endpackage

// File: rtl/btc_div.sv
module btc_div #(
  parameter int DVW = 64,
  parameter int DSW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [DVW-1:0] dividend,
  input  logic [DSW-1:0] divisor,
  output logic           done,
  output logic [DVW-1:0] quot
);
  localparam int CNTW = $clog2(DVW + 1);

  logic [DVW-1:0]  sh_q;
  logic [DSW:0]    rem_q;
  logic [DSW-1:0]  dsr_q;
  logic [CNTW-1:0] cnt_q;
  logic            run_q;
  logic [DSW:0]    rem_sh;
  logic [DSW:0]    rem_nx;
  logic            fits;

  always_comb begin
    rem_sh = {rem_q[DSW-1:0], sh_q[DVW-1]};
    fits   = rem_sh >= {1'b0, dsr_q};
    rem_nx = fits ? rem_sh - {1'b0, dsr_q} : rem_sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      rem_q <= '0;
      dsr_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        sh_q  <= dividend;
        rem_q <= '0;
        dsr_q <= divisor;
        cnt_q <= CNTW'(DVW);
        run_q <= 1'b1;
      end else if (run_q) begin
        sh_q  <= {sh_q[DVW-2:0], fits};
        rem_q <= rem_nx;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNTW'(1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

  assign quot = sh_q;
endmodule

// File: rtl/btc_rate_lut.sv
module btc_rate_lut
  import btc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] key_in,
  input  logic [W-1:0] cap_in,
  output logic [W-1:0] rate
);
  logic [W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = LUT_ROWS - 1; i >= 0; i--) begin
      if (key_in >= W'(lut_key(i))) pick = W'(lut_val(i));
    end
    rate = (pick > cap_in) ? cap_in : pick;
  end
endmodule

// File: rtl/boost_tgt_calc.sv
module boost_tgt_calc
  import btc_pkg::*;
#(
  parameter int W   = 32,
  parameter int NCH = NSET,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ev_valid,
  output logic           ev_ready,
  input  logic [1:0]     ev_kind,
  input  logic [CHW-1:0] ev_chan,
  input  logic [W-1:0]   avg_cnt,
  input  logic [W-1:0]   cur_freq,
  input  logic [W-1:0]   max_freq,
  input  logic [W-1:0]   cpu_freq,
  input  logic [1:0]     arm_in,
  output logic           res_valid,
  input  logic           res_ready,
  output logic [W-1:0]   boost_out,
  output logic [W-1:0]   target_out,
  output logic [W-1:0]   avg_wm_hi,
  output logic [W-1:0]   avg_wm_lo,
  output logic [W-1:0]   raw_wm_hi,
  output logic [W-1:0]   raw_wm_lo,
  output logic           arm_below,
  output logic           arm_above
);
  localparam int DVW = 2 * W;
  localparam int DSW = CW;

  typedef enum logic [2:0] {
    S_IDLE, S_BOOST, S_BAND, S_HIW, S_LOW, S_AVG, S_TGT, S_OUT
  } st_e;

  function automatic logic [W-1:0] sat_w(input logic [DVW-1:0] v);
    return (|v[DVW-1:W]) ? {W{1'b1}} : v[W-1:0];
  endfunction

  st_e            st_q;
  ev_kind_e       kind_q;
  logic [CHW-1:0] ch_q;
  logic [W-1:0]   avg_q, cur_q, max_q, cpu_q;
  logic [1:0]     arm_q;
  logic           fired_q;
  logic [W-1:0]   a12_q;
  logic [W-1:0]   bank_q [NCH];

  coef_t          cset;
  logic [W-1:0]   boost_old;
  logic           is_sample, need_div, div_go, div_done, step_end;
  logic [DVW-1:0] dvd, quot;
  logic [DSW-1:0] dsr;
  logic [W-1:0]   nb_c, band_c, tgt_c, lut_rate, q_sat, up_sum;
  logic           below_c, above_c, dep_on, dep_hit;

  assign cset      = coef_of(int'(ch_q));
  assign boost_old = bank_q[ch_q];
  assign is_sample = (kind_q == EV_SAMPLE) || (kind_q == EV_SAMPLE_ALT);
  assign need_div  = (st_q == S_BAND) || (st_q == S_HIW) || (st_q == S_LOW) ||
                     (st_q == S_AVG) || (st_q == S_TGT) || (st_q == S_BOOST && !is_sample);
  assign div_go    = need_div && !fired_q;
  assign step_end  = (st_q == S_BOOST && is_sample) || (need_div && div_done);
  assign dep_on    = (cset.dep_floor != 32'd0);
  assign dep_hit   = dep_on && (avg_q >= W'(cset.dep_floor));

  // operand selection for the shared divider
  always_comb begin
    dvd = '0;
    dsr = DSW'(PCT);
    case (st_q)
      S_BOOST: dvd = DVW'(boost_old) *
                     DVW'((kind_q == EV_UPPER) ? cset.grow_pct : cset.decay_pct);
      S_BAND: begin
        dvd = DVW'(max_q) * DVW'(BAND_PPT);
        dsr = DSW'(PPT);
      end
      S_HIW: dvd = DVW'(cur_q) * DVW'(PERIOD) * DVW'(cset.hi_pct);
      S_LOW: dvd = DVW'(cur_q) * DVW'(PERIOD) * DVW'(cset.lo_pct);
      S_AVG: begin
        dvd = DVW'(avg_q);
        dsr = DSW'(PERIOD);
      end
      S_TGT: dvd = DVW'(a12_q) * DVW'(cset.sustain);
      default: dvd = '0;
    endcase
  end

  btc_div #(.DVW(DVW), .DSW(DSW)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_go),
    .dividend(dvd), .divisor(dsr), .done(div_done), .quot(quot)
  );

  btc_rate_lut #(.W(W)) u_lut (
    .key_in(cpu_q), .cap_in(max_q), .rate(lut_rate)
  );

  // boost update and re-arm decision
  always_comb begin
    q_sat  = sat_w(quot);
    up_sum = sat_w(quot + DVW'(STEP));
    nb_c    = boost_old;
    below_c = arm_q[0];
    above_c = arm_q[1];
    case (kind_q)
      EV_UPPER: begin
        below_c = 1'b1;
        if (up_sum >= max_q) begin
          nb_c    = max_q;
          above_c = 1'b0;
        end else begin
          nb_c    = up_sum;
          above_c = 1'b1;
        end
      end
      EV_LOWER: begin
        above_c = 1'b1;
        if (q_sat < W'(FLOOR)) begin
          nb_c    = '0;
          below_c = 1'b0;
        end else begin
          nb_c    = q_sat;
          below_c = 1'b1;
        end
      end
      default: ;
    endcase
    if (dep_on) begin
      if (dep_hit) below_c = 1'b1;
      else if (nb_c == '0) below_c = 1'b0;
    end
  end

  always_comb begin
    band_c = sat_w(quot * DVW'(PERIOD));
    tgt_c  = sat_w(quot + DVW'(boost_out));
    if (dep_hit && lut_rate > tgt_c) tgt_c = lut_rate;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) bank_q[c] <= '0;
    end else if (st_q == S_BOOST && step_end) begin
      for (int c = 0; c < NCH; c++)
        if (ch_q == CHW'(c)) bank_q[c] <= nb_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      kind_q <= EV_SAMPLE;
      ch_q <= '0;
      avg_q <= '0;
      cur_q <= '0;
      max_q <= '0;
      cpu_q <= '0;
      arm_q <= '0;
      fired_q <= 1'b0;
      a12_q <= '0;
      boost_out <= '0;
      target_out <= '0;
      avg_wm_hi <= '0;
      avg_wm_lo <= '0;
      raw_wm_hi <= '0;
      raw_wm_lo <= '0;
      arm_below <= 1'b0;
      arm_above <= 1'b0;
    end else begin
      if (div_go) fired_q <= 1'b1;
      else if (step_end) fired_q <= 1'b0;
      case (st_q)
        S_IDLE: if (ev_valid) begin
          kind_q <= ev_kind_e'(ev_kind);
          ch_q   <= ev_chan;
          avg_q  <= avg_cnt;
          cur_q  <= cur_freq;
          max_q  <= max_freq;
          cpu_q  <= cpu_freq;
          arm_q  <= arm_in;
          st_q   <= S_BOOST;
        end
        S_BOOST: if (step_end) begin
          boost_out <= nb_c;
          arm_below <= below_c;
          arm_above <= above_c;
          st_q      <= S_BAND;
        end
        S_BAND: if (step_end) begin
          avg_wm_hi <= sat_w(DVW'(avg_q) + DVW'(band_c));
          avg_wm_lo <= ((avg_q > band_c) ? avg_q : band_c) - band_c;
          st_q      <= S_HIW;
        end
        S_HIW: if (step_end) begin
          raw_wm_hi <= sat_w(quot);
          st_q      <= S_LOW;
        end
        S_LOW: if (step_end) begin
          raw_wm_lo <= sat_w(quot);
          st_q      <= S_AVG;
        end
        S_AVG: if (step_end) begin
          a12_q <= quot[W-1:0];
          st_q  <= S_TGT;
        end
        S_TGT: if (step_end) begin
          target_out <= tgt_c;
          st_q       <= S_OUT;
        end
        default: if (res_ready) st_q <= S_IDLE;
      endcase
    end
  end

  assign ev_ready  = (st_q == S_IDLE);
  assign res_valid = (st_q == S_OUT);
endmodule

// File: rtl/btc_chk.sv
module btc_chk
  import btc_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ev_valid,
  input logic         ev_ready,
  input logic         res_valid,
  input logic         res_ready,
  input logic [W-1:0] boost_out,
  input logic [W-1:0] target_out,
  input logic [W-1:0] avg_wm_hi,
  input logic [W-1:0] avg_wm_lo,
  input logic         arm_below,
  input logic         arm_above,
  input logic [1:0]   kind_seen
);
  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready |=> !ev_ready);

  assert_hold_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(boost_out) && $stable(target_out)
      && $stable(avg_wm_hi) && $stable(arm_below) && $stable(arm_above));

  assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_ready && res_valid));

  assert_upper_rearm_below_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && kind_seen == EV_UPPER |-> arm_below);

  assert_lower_rearm_above_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && kind_seen == EV_LOWER |-> arm_above);

  assert_collapse_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && kind_seen == EV_LOWER |-> (boost_out == '0 || boost_out >= W'(FLOOR)));

  assert_band_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> avg_wm_lo <= avg_wm_hi);
endmodule

bind boost_tgt_calc btc_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
  .res_valid(res_valid), .res_ready(res_ready), .boost_out(boost_out),
  .target_out(target_out), .avg_wm_hi(avg_wm_hi), .avg_wm_lo(avg_wm_lo),
  .arm_below(arm_below), .arm_above(arm_above), .kind_seen(kind_q)
);

// File: tb/boost_tgt_calc_test.sv
module boost_tgt_calc_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] ALL1 = 64'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 1'b0;
  logic [1:0] ev_kind = 2'b00;
  logic ev_chan = 1'b0;
  logic [31:0] avg_cnt = '0, cur_freq = '0, max_freq = '0, cpu_freq = '0;
  logic [1:0] arm_in = 2'b00;
  logic res_ready = 1'b0;
  logic ev_ready, res_valid, arm_below, arm_above;
  logic [31:0] boost_out, target_out, avg_wm_hi, avg_wm_lo, raw_wm_hi, raw_wm_lo;

  int n_total = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  boost_tgt_calc uut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_kind(ev_kind), .ev_chan(ev_chan), .avg_cnt(avg_cnt), .cur_freq(cur_freq),
    .max_freq(max_freq), .cpu_freq(cpu_freq), .arm_in(arm_in),
    .res_valid(res_valid), .res_ready(res_ready), .boost_out(boost_out),
    .target_out(target_out), .avg_wm_hi(avg_wm_hi), .avg_wm_lo(avg_wm_lo),
    .raw_wm_hi(raw_wm_hi), .raw_wm_lo(raw_wm_lo),
    .arm_below(arm_below), .arm_above(arm_above)
  );

  typedef struct packed {
    logic [1:0]  k;
    logic        ch;
    logic [31:0] avg;
    logic [31:0] cur;
    logic [31:0] mx;
    logic [31:0] cpu;
    logic [1:0]  arm;
    logic [31:0] eb;
    logic        ebl;
    logic        eab;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'b01, 1'b0, 32'd20000, 32'd800000, 32'd1000000, 32'd0,       2'b00, 32'd16000,  1'b1, 1'b1},
    '{2'b01, 1'b0, 32'd35000, 32'd800000, 32'd1000000, 32'd0,       2'b00, 32'd48000,  1'b1, 1'b1},
    '{2'b10, 1'b0, 32'd9000,  32'd600000, 32'd1000000, 32'd0,       2'b00, 32'd24000,  1'b1, 1'b1},
    '{2'b10, 1'b0, 32'd5,     32'd600000, 32'd1000000, 32'd0,       2'b00, 32'd12000,  1'b1, 1'b1},
    '{2'b10, 1'b0, 32'd7000,  32'd600000, 32'd1000000, 32'd0,       2'b00, 32'd0,      1'b0, 1'b1},
    '{2'b00, 1'b0, 32'd7000,  32'd600000, 32'd1000000, 32'd0,       2'b10, 32'd0,      1'b0, 1'b1},
    '{2'b01, 1'b1, 32'd60000, 32'd400000, 32'd100000,  32'd1300000, 2'b00, 32'd16000,  1'b1, 1'b1},
    '{2'b01, 1'b1, 32'd70000, 32'd400000, 32'd100000,  32'd900000,  2'b00, 32'd100000, 1'b1, 1'b0},
    '{2'b10, 1'b1, 32'd1000,  32'd400000, 32'd100000,  32'd1500000, 2'b00, 32'd90000,  1'b1, 1'b1},
    '{2'b00, 1'b1, 32'd55000, 32'd400000, 32'd2000000, 32'd600000,  2'b00, 32'd90000,  1'b1, 1'b0},
    '{2'b01, 1'b0, 32'd12000, 32'd500000, 32'd1000000, 32'd0,       2'b00, 32'd16000,  1'b1, 1'b1},
    '{2'b11, 1'b0, 32'd12000, 32'd500000, 32'd1000000, 32'd0,       2'b01, 32'd16000,  1'b1, 1'b0}
  };

  task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    n_total++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic logic [63:0] sat(input logic [63:0] x);
    return (x > ALL1) ? ALL1 : x;
  endfunction

  // expected watermarks and target from R8..R11, R13
  task automatic model(input logic ch, input logic [63:0] a, c, m, p, b,
                       output logic [63:0] ahi, alo, rhi, rlo, tg);
    logic [63:0] band, ut, lt, su, dep, lk, t;
    ut  = ch ? 64'd27 : 64'd60;
    lt  = ch ? 64'd10 : 64'd40;
    su  = ch ? 64'd370 : 64'd166;
    dep = ch ? 64'd50000 : 64'd0;
    band = sat((m * 6 / 1000) * 12);
    ahi = sat(a + band);
    alo = ((a > band) ? a : band) - band;
    rhi = sat(c * 12 * ut / 100);
    rlo = sat(c * 12 * lt / 100);
    t = sat((a / 12) * su / 100 + b);
    if      (p >= 1400000) lk = ALL1;
    else if (p >= 1200000) lk = 750000;
    else if (p >= 1100000) lk = 600000;
    else if (p >= 1000000) lk = 500000;
    else if (p >= 800000)  lk = 375000;
    else if (p >= 500000)  lk = 200000;
    else if (p >= 250000)  lk = 100000;
    else                   lk = 0;
    if (lk > m) lk = m;
    if (dep != 0 && a >= dep && lk > t) t = lk;
    tg = t;
  endtask

  task automatic run_ev(input vec_t v, input string tag);
    logic [63:0] ahi, alo, rhi, rlo, tg;
    int n;
    @(negedge clk);
    chk("R1", {tag, " ready when idle"}, 64'(ev_ready), 64'd1);
    ev_valid = 1'b1; ev_kind = v.k; ev_chan = v.ch; avg_cnt = v.avg;
    cur_freq = v.cur; max_freq = v.mx; cpu_freq = v.cpu; arm_in = v.arm;
    @(negedge clk);
    ev_valid = 1'b0;
    chk("R1", {tag, " busy after accept"}, 64'(ev_ready), 64'd0);
    n = 0;
    while (!res_valid && n < 5000) begin
      @(negedge clk);
      n++;
    end
    model(v.ch, 64'(v.avg), 64'(v.cur), 64'(v.mx), 64'(v.cpu), 64'(v.eb), ahi, alo, rhi, rlo, tg);
    chk("R2/R4/R6/R12/R13", {tag, " boost"}, 64'(boost_out), 64'(v.eb));
    chk("R3/R4/R6/R7", {tag, " arm_below"}, 64'(arm_below), 64'(v.ebl));
    chk("R3/R5/R6", {tag, " arm_above"}, 64'(arm_above), 64'(v.eab));
    chk("R8", {tag, " avg hi"}, 64'(avg_wm_hi), ahi);
    chk("R8", {tag, " avg lo"}, 64'(avg_wm_lo), alo);
    chk("R9", {tag, " raw hi"}, 64'(raw_wm_hi), rhi);
    chk("R9", {tag, " raw lo"}, 64'(raw_wm_lo), rlo);
    chk("R10/R11", {tag, " target"}, 64'(target_out), tg);
    repeat (2) @(negedge clk);
    chk("R1", {tag, " held under back-pressure"}, 64'({res_valid, ev_ready}), 64'b10);
    chk("R1", {tag, " boost stable"}, 64'(boost_out), 64'(v.eb));
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk("R1", {tag, " idle after handoff"}, 64'({res_valid, ev_ready}), 64'b01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_total++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    logic [63:0] b64;
    vec_t v;
    repeat (3) @(negedge clk);
    chk("R1", "reset ready", 64'(ev_ready), 64'd1);
    chk("R1", "reset valid", 64'(res_valid), 64'd0);
    chk("R12", "reset boost", 64'(boost_out), 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_ev(VECS[i], $sformatf("vec%0d", i));

    // R7 forced-off: channel 1 with zero boost right after reset (R12)
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    v = '{2'b00, 1'b1, 32'd1000, 32'd300000, 32'd1000000, 32'd0, 2'b11, 32'd0, 1'b0, 1'b1};
    run_ev(v, "R7 forced off");

    // R13: boost chain on channel 1 up to 32-bit saturation and clamp
    b64 = 0;
    for (int j = 0; j < 7; j++) begin
      b64 = b64 * 800 / 100 + 16000;
      v = '{2'b01, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, 2'b00, 32'd0, 1'b1, 1'b1};
      if (b64 >= ALL1) begin
        b64 = ALL1;
        v.eab = 1'b0;
      end
      v.eb = b64[31:0];
      run_ev(v, $sformatf("R13 chain %0d", j));
    end

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule